// File: doc/BRIEF.md
# Teletext Page Clear Sequencer

This block fills teletext page memory with a clear code by driving a write stream of address and data, one location per accepted transfer. Three sources can ask for a clear. The first is the reset itself, which wipes every block. The second is the data-capture path, which clears the rows of a freshly acquired page as soon as its header arrives. The third is software, which asks for a whole block to be wiped. The block keeps to one page clear per TV line, so a request may have to wait. It also exposes a busy flag.

A hardware clear is forced by a header pulse. It happens when the header's erase bit is set, or when the header is the first one after a new-page request pulse. It starts at once and covers the capture block's body rows and the extension rows that belong to that page. A software request is latched internally and starts on the next line-start strobe, provided that the sequencer is idle and no hardware clear is forced in that same cycle. A hardware clear that arrives while a software clear is running takes the write port. The interrupted software clear then runs again from its first location on a later line.

The write port is a valid/ready stream. While `wr_valid_o` is high and `wr_ready_i` is low, the address and data hold. The next location is presented only after a transfer is accepted. The single exception is a hardware clear that takes over from a running software clear: the stream then moves straight to the first hardware location. A hardware clear needs 1000 accepted writes. To finish within its line, the memory must accept writes fast enough for that.

Top module: `pcc_page_clear`

## Requirements
- R1: From the cycle after reset is released, the block writes 20h to every location of all 16 blocks, one location per accepted transfer. The order is block ascending, then row 0..25 ascending, then column 0..39 ascending, for 16640 writes in total. `busy_o` is 1 during reset and throughout this clear.
- R2: The write address is block*2048 + row*64 + column. This is a 15-bit value with the block in bits 14:11, the row in bits 10:6 and the column in bits 5:0. Within one row, the columns 0 to 39 are written in ascending order.
- R3: While `wr_valid_o` is 1 and `wr_ready_i` is 0, valid, address and data stay unchanged on the next cycle, unless a hardware clear takes over in that cycle.
- R4: A header pulse forces a hardware clear when its erase bit is 1, or when a new-page request pulse has been seen since the previous header. A header with neither condition produces no writes.
- R5: A hardware clear starts presenting writes in the cycle after the header pulse. It writes 20h to rows 1..23 of the capture block, then to the packet-27 row `p27_row_i` of the extension block, then to the packet-24 row, for 1000 writes in total.
- R6: The packet-24 row is row 24 of the capture block when `x24_pos_i` is 1, and row 0 of the extension block when it is 0.
- R7: At most one hardware clear starts per line. A second forcing header in the same line produces no writes. A hardware clear completes within `LINE_CLKS` cycles.
- R8: A software clear pulse latches the block select. The clear starts at the next line-start strobe that finds the sequencer idle with no hardware clear forced in that cycle. It writes rows 0..25 of that block, for 1040 writes.
- R9: `busy_o` is 1 from the cycle after a software clear pulse until the cycle after the last write of that clear, and is then 0 unless another request is waiting.
- R10: A hardware clear forced while a software clear is running takes over at once. The software request stays pending, with `busy_o` at 1, and runs again in full on a later line.
- R11: When the inversion bit, sampled with the software clear pulse, is 1 and the selected block is 8, that software clear writes 00h instead of 20h.
- R12: Headers that arrive during the reset clear have no effect. A software request made during the reset clear is held until a later line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start_i | input | 1 | One-cycle strobe at the start of each TV line |
| hdr_valid_i | input | 1 | One-cycle pulse when a page header is received |
| hdr_erase_i | input | 1 | Erase bit carried by the header |
| page_req_i | input | 1 | One-cycle pulse for a new page request |
| sw_clear_i | input | 1 | Software clear request pulse (not latched by software) |
| sw_blk_i | input | 4 | Block to clear on a software request |
| inv_en_i | input | 1 | Inversion bit, sampled with the software request |
| x24_pos_i | input | 1 | Packet-24 row placement select |
| cap_blk_i | input | 4 | Block that holds the basic page being captured |
| ext_blk_i | input | 4 | Block that holds the extension rows |
| p27_row_i | input | 5 | Extension row used for packet 27 |
| wr_valid_o | output | 1 | Write stream valid |
| wr_ready_i | input | 1 | Write stream ready |
| wr_addr_o | output | 15 | Write address {block, row, column} |
| wr_data_o | output | 8 | Fill byte |
| busy_o | output | 1 | Reset clear running, or software clear pending or running |

## Verification
Every result is due on a fixed cycle. The first write appears one cycle after the header pulse, the line-start strobe or the reset release that caused it. `busy_o` rises one cycle after a software request, and the stream advances one location per cycle in which valid and ready are both high. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. On the next falling edge it compares valid, address, data and busy against that model, so each comparison lands exactly one register stage after its stimulus. Totals of accepted writes and idle checks after ignored headers are taken once the stream has gone quiet.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  // Kind of fill job held by the write sequencer.
  typedef enum logic [1:0] {
    JOB_BOOT = 2'd0,
    JOB_HW   = 2'd1,
    JOB_SW   = 2'd2
  } job_e;
endpackage

// File: rtl/pcc_walker.sv
module pcc_walker
  import pcc_pkg::*;
#(
  parameter int BLK_W      = 4,
  parameter int ROW_W      = 5,
  parameter int COL_W      = 6,
  parameter int NUM_BLOCKS = 16,
  parameter int NUM_ROWS   = 26,
  parameter int NUM_COLS   = 40,
  parameter int BODY_FIRST = 1,
  parameter int BODY_LAST  = 23,
  parameter int DATA_W     = 8,
  localparam int ADDR_W    = BLK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  job_e              kind_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [BLK_W-1:0]  ext_blk_i,
  input  logic [ROW_W-1:0]  p27_row_i,
  input  logic              x24_i,
  input  logic [DATA_W-1:0] fill_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output job_e              kind_o,
  output logic              done_o
);
  localparam int HW_SLOTS = BODY_LAST - BODY_FIRST + 3;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);
  localparam logic [ROW_W-1:0] LAST_HW  = ROW_W'(HW_SLOTS - 1);
  localparam logic [ROW_W-1:0] P27_SLOT = ROW_W'(HW_SLOTS - 2);
  localparam logic [ROW_W-1:0] BODY0    = ROW_W'(BODY_FIRST);
  localparam logic [ROW_W-1:0] X24_ROW  = ROW_W'(BODY_LAST + 1);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  logic              active_q;
  job_e              kind_q;
  logic [BLK_W-1:0]  blk_q;
  logic [BLK_W-1:0]  ext_q;
  logic [ROW_W-1:0]  p27_q;
  logic              x24_q;
  logic [ROW_W-1:0]  slot_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] fill_q;

  logic [BLK_W-1:0]  cur_blk;
  logic [ROW_W-1:0]  cur_row;
  logic [ROW_W-1:0]  last_slot;
  logic              fire;
  logic              row_end;
  logic              slot_end;
  logic              job_end;

  // Map the slot counter onto a (block, row) pair for the running job.
  always_comb begin
    cur_blk = blk_q;
    cur_row = slot_q;
    if (kind_q == JOB_HW) begin
      if (slot_q == P27_SLOT) begin
        cur_blk = ext_q;
        cur_row = p27_q;
      end else if (slot_q == LAST_HW) begin
        if (x24_q) begin
          cur_row = X24_ROW;
        end else begin
          cur_blk = ext_q;
          cur_row = '0;
        end
      end else begin
        cur_row = slot_q + BODY0;
      end
    end
  end

  assign last_slot = (kind_q == JOB_HW) ? LAST_HW : LAST_ROW;
  assign fire      = active_q & wr_ready_i;
  assign row_end   = (col_q == LAST_COL);
  assign slot_end  = (slot_q == last_slot);
  assign job_end   = row_end & slot_end & ((kind_q != JOB_BOOT) | (blk_q == LAST_BLK));
  assign done_o    = fire & job_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      kind_q   <= JOB_BOOT;
      blk_q    <= '0;
      ext_q    <= '0;
      p27_q    <= '0;
      x24_q    <= 1'b0;
      slot_q   <= '0;
      col_q    <= '0;
      fill_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      kind_q   <= kind_i;
      blk_q    <= blk_i;
      ext_q    <= ext_blk_i;
      p27_q    <= p27_row_i;
      x24_q    <= x24_i;
      slot_q   <= '0;
      col_q    <= '0;
      fill_q   <= fill_i;
    end else if (fire) begin
      if (!row_end) begin
        col_q <= col_q + COL_W'(1);
      end else begin
        col_q <= '0;
        if (!slot_end) begin
          slot_q <= slot_q + ROW_W'(1);
        end else begin
          slot_q <= '0;
          if (job_end) active_q <= 1'b0;
          else         blk_q    <= blk_q + BLK_W'(1);
        end
      end
    end
  end

  assign wr_valid_o = active_q;
  assign wr_addr_o  = {cur_blk, cur_row, col_q};
  assign wr_data_o  = fill_q;
  assign kind_o     = kind_q;

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i && !start_i |=>
      wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  // R2
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_addr_o[COL_W-1:0] <= LAST_COL));
endmodule

// File: rtl/pcc_arbiter.sv
module pcc_arbiter
  import pcc_pkg::*;
#(
  parameter int BLK_W      = 4,
  parameter int DATA_W     = 8,
  parameter int INV_BLK    = 8,
  parameter logic [DATA_W-1:0] SPACE_CODE = 8'h20,
  parameter logic [DATA_W-1:0] INV_CODE   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start_i,
  input  logic              hdr_valid_i,
  input  logic              hdr_erase_i,
  input  logic              page_req_i,
  input  logic              sw_clear_i,
  input  logic [BLK_W-1:0]  sw_blk_i,
  input  logic              inv_en_i,
  input  logic [BLK_W-1:0]  cap_blk_i,
  input  logic              walk_active_i,
  input  job_e              walk_kind_i,
  input  logic              walk_done_i,
  output logic              start_o,
  output job_e              start_kind_o,
  output logic [BLK_W-1:0]  start_blk_o,
  output logic [DATA_W-1:0] start_fill_o,
  output logic              busy_o
);
  localparam logic [BLK_W-1:0] INV_SEL = BLK_W'(INV_BLK);

  logic             boot_q;
  logic             armed_q;
  logic             hwline_q;
  logic             wait_q;
  logic [BLK_W-1:0] lblk_q;
  logic             linv_q;
  logic [1:0]       hw_cnt_q;

  logic boot_start;
  logic hw_trig;
  logic sw_start;
  logic preempt;
  logic sw_running;

  assign sw_running = walk_active_i & (walk_kind_i == JOB_SW);
  assign boot_start = boot_q & ~walk_active_i;
  assign hw_trig    = hdr_valid_i & ~boot_q & (hdr_erase_i | armed_q) & ~hwline_q;
  assign sw_start   = line_start_i & wait_q & ~boot_q & ~hw_trig & ~walk_active_i;
  assign preempt    = hw_trig & sw_running;

  // Start selection: reset clear first, then the header clear, then software.
  always_comb begin
    start_o      = boot_start | hw_trig | sw_start;
    start_kind_o = JOB_SW;
    start_blk_o  = lblk_q;
    start_fill_o = (linv_q && (lblk_q == INV_SEL)) ? INV_CODE : SPACE_CODE;
    if (boot_start) begin
      start_kind_o = JOB_BOOT;
      start_blk_o  = '0;
      start_fill_o = SPACE_CODE;
    end else if (hw_trig) begin
      start_kind_o = JOB_HW;
      start_blk_o  = cap_blk_i;
      start_fill_o = SPACE_CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q   <= 1'b1;
      armed_q  <= 1'b0;
      hwline_q <= 1'b0;
      wait_q   <= 1'b0;
      lblk_q   <= '0;
      linv_q   <= 1'b0;
    end else begin
      if (walk_done_i && (walk_kind_i == JOB_BOOT)) boot_q <= 1'b0;
      armed_q  <= page_req_i | (armed_q & ~(hdr_valid_i & ~boot_q));
      hwline_q <= line_start_i ? hw_trig : (hwline_q | hw_trig);
      wait_q   <= sw_clear_i | (wait_q & ~sw_start) | preempt;
      if (sw_clear_i) begin
        lblk_q <= sw_blk_i;
        linv_q <= inv_en_i;
      end
    end
  end

  assign busy_o = boot_q | wait_q | sw_running;

  // Checker: header clears launched since the last line start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_cnt_q <= '0;
    end else if (line_start_i) begin
      hw_cnt_q <= (start_o && start_kind_o == JOB_HW) ? 2'd1 : 2'd0;
    end else if (start_o && start_kind_o == JOB_HW && hw_cnt_q != 2'd3) begin
      hw_cnt_q <= hw_cnt_q + 2'd1;
    end
  end

  // R7
  one_hw_per_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_cnt_q <= 2'd1);

  // R9
  busy_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear_i |=> busy_o);
endmodule

// File: rtl/pcc_page_clear.sv
module pcc_page_clear
  import pcc_pkg::*;
#(
  parameter int BLK_W      = 4,
  parameter int ROW_W      = 5,
  parameter int COL_W      = 6,
  parameter int NUM_BLOCKS = 16,
  parameter int NUM_ROWS   = 26,
  parameter int NUM_COLS   = 40,
  parameter int BODY_FIRST = 1,
  parameter int BODY_LAST  = 23,
  parameter int DATA_W     = 8,
  parameter int INV_BLK    = 8,
  parameter int LINE_CLKS  = 1100,
  localparam int ADDR_W    = BLK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start_i,
  input  logic              hdr_valid_i,
  input  logic              hdr_erase_i,
  input  logic              page_req_i,
  input  logic              sw_clear_i,
  input  logic [BLK_W-1:0]  sw_blk_i,
  input  logic              inv_en_i,
  input  logic              x24_pos_i,
  input  logic [BLK_W-1:0]  cap_blk_i,
  input  logic [BLK_W-1:0]  ext_blk_i,
  input  logic [ROW_W-1:0]  p27_row_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o
);
  localparam int AGE_W = $clog2(LINE_CLKS + 1);

  logic              start;
  job_e              start_kind;
  logic [BLK_W-1:0]  start_blk;
  logic [DATA_W-1:0] start_fill;
  job_e              walk_kind;
  logic              walk_done;

  pcc_arbiter #(
    .BLK_W   (BLK_W),
    .DATA_W  (DATA_W),
    .INV_BLK (INV_BLK)
  ) u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_start_i  (line_start_i),
    .hdr_valid_i   (hdr_valid_i),
    .hdr_erase_i   (hdr_erase_i),
    .page_req_i    (page_req_i),
    .sw_clear_i    (sw_clear_i),
    .sw_blk_i      (sw_blk_i),
    .inv_en_i      (inv_en_i),
    .cap_blk_i     (cap_blk_i),
    .walk_active_i (wr_valid_o),
    .walk_kind_i   (walk_kind),
    .walk_done_i   (walk_done),
    .start_o       (start),
    .start_kind_o  (start_kind),
    .start_blk_o   (start_blk),
    .start_fill_o  (start_fill),
    .busy_o        (busy_o)
  );

  pcc_walker #(
    .BLK_W      (BLK_W),
    .ROW_W      (ROW_W),
    .COL_W      (COL_W),
    .NUM_BLOCKS (NUM_BLOCKS),
    .NUM_ROWS   (NUM_ROWS),
    .NUM_COLS   (NUM_COLS),
    .BODY_FIRST (BODY_FIRST),
    .BODY_LAST  (BODY_LAST),
    .DATA_W     (DATA_W)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .kind_i     (start_kind),
    .blk_i      (start_blk),
    .ext_blk_i  (ext_blk_i),
    .p27_row_i  (p27_row_i),
    .x24_i      (x24_pos_i),
    .fill_i     (start_fill),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .kind_o     (walk_kind),
    .done_o     (walk_done)
  );

  // Checker: cycles spent by the current header clear.
  logic [AGE_W-1:0] hw_age_q;
  always_ff @(posedge clk) begin
    if (!rst_n || start) hw_age_q <= '0;
    else if (wr_valid_o && walk_kind == JOB_HW && hw_age_q != AGE_W'(LINE_CLKS))
      hw_age_q <= hw_age_q + AGE_W'(1);
  end

  // R7
  hw_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && walk_kind == JOB_HW |-> hw_age_q < AGE_W'(LINE_CLKS));

  // R12
  boot_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && walk_kind == JOB_BOOT && hdr_valid_i |=>
      !wr_valid_o || walk_kind == JOB_BOOT);

  // R8
  sw_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && walk_kind == JOB_SW) && !$past(wr_valid_o && walk_kind == JOB_SW)
      |-> $past(line_start_i));
endmodule

// File: tb/tb_pcc_page_clear.sv
module tb_pcc_page_clear;
  localparam int NB = 16, NR = 26, NC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 0, hdr = 0, hdr_erase = 0, page_req = 0, sw_clear = 0;
  logic [3:0] sw_blk = '0, cap_blk = 4'd2, ext_blk = 4'd9;
  logic inv_en = 0, x24 = 0;
  logic [4:0] p27_row = 5'd7;
  logic wr_ready = 1'b1;
  logic wr_valid, busy;
  logic [14:0] wr_addr;
  logic [7:0] wr_data;

  always #5 clk = ~clk;

  pcc_page_clear dut (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start), .hdr_valid_i(hdr),
    .hdr_erase_i(hdr_erase), .page_req_i(page_req), .sw_clear_i(sw_clear),
    .sw_blk_i(sw_blk), .inv_en_i(inv_en), .x24_pos_i(x24), .cap_blk_i(cap_blk),
    .ext_blk_i(ext_blk), .p27_row_i(p27_row), .wr_valid_o(wr_valid),
    .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .busy_o(busy));

  int checks = 0, errors = 0, cyc = 0, wr_count = 0;
  string phase = "R1";
  bit stall_en = 0, started = 0;

  // Behavioural reference: a queue of row base addresses still to be filled.
  int m_rows[$];
  int m_col, m_kind, m_fill;   // kind: 0 reset, 1 header, 2 software
  bit m_active, m_boot, m_armed, m_hwline, m_wait, m_linv;
  int m_lblk;
  bit f_fire, f_hw, f_boot, f_sw, f_pre;

  function automatic int rbase(int b, int r);
    return b * 2048 + r * 64;
  endfunction

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst_n && wr_valid && wr_ready) wr_count++;
    if (!rst_n) begin
      m_rows.delete(); m_col = 0; m_kind = 0; m_fill = 0; m_active = 0;
      m_boot = 1; m_armed = 0; m_hwline = 0; m_wait = 0; m_linv = 0; m_lblk = 0;
    end else begin
      f_fire = m_active && wr_ready;
      f_hw   = hdr && !m_boot && (hdr_erase || m_armed) && !m_hwline;
      f_boot = m_boot && !m_active;
      f_sw   = line_start && m_wait && !m_boot && !f_hw && !m_active;
      f_pre  = f_hw && m_active && m_kind == 2;
      if (f_fire) begin
        m_col++;
        if (m_col == NC) begin
          m_col = 0;
          void'(m_rows.pop_front());
          if (m_rows.size() == 0) begin
            m_active = 0;
            if (m_kind == 0) m_boot = 0;
          end
        end
      end
      if (f_boot || f_hw || f_sw) begin
        m_rows.delete(); m_col = 0; m_active = 1; m_fill = 8'h20;
        if (f_boot) begin
          m_kind = 0;
          for (int b = 0; b < NB; b++) for (int r = 0; r < NR; r++) m_rows.push_back(rbase(b, r));
        end else if (f_hw) begin
          m_kind = 1;
          for (int r = 1; r <= 23; r++) m_rows.push_back(rbase(cap_blk, r));
          m_rows.push_back(rbase(ext_blk, p27_row));
          m_rows.push_back(x24 ? rbase(cap_blk, 24) : rbase(ext_blk, 0));
        end else begin
          m_kind = 2;
          if (m_linv && m_lblk == 8) m_fill = 0;
          for (int r = 0; r < NR; r++) m_rows.push_back(rbase(m_lblk, r));
        end
      end
      m_armed  = page_req || (m_armed && !(hdr && !m_boot));
      m_hwline = line_start ? f_hw : (m_hwline || f_hw);
      m_wait   = sw_clear || (m_wait && !f_sw) || f_pre;
      if (sw_clear) begin m_lblk = sw_blk; m_linv = inv_en; end
    end
  end

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      check_eq({phase, " valid"}, int'(wr_valid), int'(m_active));
      check_eq({phase, " busy (R9)"}, int'(busy), int'(m_boot || m_wait || (m_active && m_kind == 2)));
      if (m_active && wr_valid) begin
        check_eq({phase, " addr (R2)"}, int'(wr_addr), m_rows[0] + m_col);
        check_eq({phase, " data"}, int'(wr_data), m_fill);
      end
    end
    wr_ready <= stall_en ? ((cyc % 7) != 3) : 1'b1;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_line();
    line_start = 1; step(1); line_start = 0;
  endtask
  task automatic pulse_hdr(bit erase);
    hdr = 1; hdr_erase = erase; step(1); hdr = 0; hdr_erase = 0;
  endtask
  task automatic pulse_sw(int blk, bit inv);
    sw_blk = 4'(blk); inv_en = inv; sw_clear = 1; step(1); sw_clear = 0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 40000 && wr_valid; i++) step(1);
  endtask

  initial begin
    step(3);
    check_eq("R1 reset valid", int'(wr_valid), 0);
    check_eq("R1 reset busy", int'(busy), 1);
    stall_en = 1;
    rst_n = 1;
    wr_count = 0;
    step(50);
    phase = "R12";
    pulse_hdr(1);
    pulse_sw(3, 0);
    phase = "R1";
    wait_idle();
    check_eq("R1 reset writes", wr_count, NB * NR * NC);
    check_eq("R12 request held", int'(busy), 1);
    stall_en = 0;
    step(2);

    phase = "R8"; wr_count = 0;
    pulse_line();
    wait_idle();
    check_eq("R8 software writes", wr_count, NR * NC);
    check_eq("R9 busy cleared", int'(busy), 0);

    phase = "R4";
    pulse_line();
    pulse_hdr(0);
    step(3);
    check_eq("R4 plain header ignored", int'(wr_valid), 0);
    page_req = 1; step(1); page_req = 0;
    step(2);
    phase = "R5"; x24 = 1; wr_count = 0;
    pulse_hdr(0);
    check_eq("R5 starts after header", int'(wr_valid), 1);
    wait_idle();
    check_eq("R5 header writes", wr_count, 1000);
    phase = "R7";
    pulse_hdr(1);
    step(3);
    check_eq("R7 second clear in line", int'(wr_valid), 0);

    phase = "R6"; x24 = 0;
    pulse_line();
    pulse_hdr(1);
    wait_idle();
    phase = "R4";
    pulse_line();
    pulse_hdr(0);
    step(3);
    check_eq("R4 request consumed", int'(wr_valid), 0);

    phase = "R10";
    pulse_sw(8, 1);
    pulse_line();
    step(100);
    pulse_hdr(1);
    wait_idle();
    check_eq("R10 software still pending", int'(busy), 1);
    phase = "R11"; wr_count = 0;
    pulse_line();
    wait_idle();
    check_eq("R11 inverted block writes", wr_count, NR * NC);
    check_eq("R11 busy cleared", int'(busy), 0);

    phase = "R3"; stall_en = 1;
    pulse_sw(5, 1);
    pulse_line();
    wait_idle();
    step(2);
    check_eq("R3 idle after stalled clear", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule